// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block hangs off a processor's byte-wide register bus and provides three 8-bit parallel ports, A, B and C. Port C is treated as two 4-bit halves with independent direction. The processor selects one of four registers with a 2-bit address, qualified by active-low chip select, read and write strobes. A clock samples the strobes, and a two-state bus sequencer turns each write strobe into exactly one register update. The sequencer's states are `BUS_IDLE` and `BUS_HOLD`. `BUS_IDLE` moves to `BUS_HOLD` when a write strobe appears, and the update is committed on that edge. `BUS_HOLD` returns to `BUS_IDLE` once the strobe is released. Reads are combinational and drive the returned byte with an output-enable.

The control address takes two kinds of command, told apart by bit 7. With bit 7 at 1 it is a configuration word, which sets the port directions and stores mode fields. With bit 7 at 0 it forces a single port C bit high or low. Only basic latched-output and buffered-input operation is implemented. Configuration words that request handshake or bidirectional modes are stored and read back, but the ports keep working in basic mode under the direction bits.

Top module: `pport_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, the control register reads 0x00, all output latches are 0 and every `*_oe` bit is 0 (all ports input) until a configuration word is written.
- R2: While `cs_n` is high, `rdata_oe` is 0 (the bus is released) and write strobes change no register.
- R3: `addr` selects the target of a read or write: 0 = port A, 1 = port B, 2 = port C, 3 = control.
- R4: A control write with bit 7 = 1 is stored whole and reads back from address 3. Its direction bits are: bit 4 = port A, bit 3 = port C[7:4], bit 1 = port B, bit 0 = port C[3:0]. A direction bit of 1 means input (oe 0) and 0 means output (oe all ones).
- R5: A configuration word clears the port A, B and C output latches to 0.
- R6: A control write with bit 7 = 0 sets port C bit number wdata[3:1] to wdata[0]. The other seven bits are unchanged, wdata[6:4] is ignored, and the stored control word is unchanged.
- R7: A port read returns the pin value for bits configured as input and the latch value for bits configured as output. For port C this is decided per half. `*_out` always carries the latch.
- R8: One write strobe commits exactly once, using the address and data of its first clocked cycle. Later changes while the strobe is still held have no effect.
- R9: Nonzero mode fields (bits 6:5 and bit 2) are stored and read back, while the ports still behave in basic mode under the direction bits.
- R10: When read and write strobes are both low with chip select low, the write commits and `rdata_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor (0 when not driven) |
| rdata_oe | output | 1 | High when the block drives the read bus |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
A register write and a register read can be requested in the same cycle when the processor pulls `rd_n` and `wr_n` low together. The bench provokes this on port B and requires the write to land while the read bus stays released. A second overlap comes from a bit set/reset command aimed at a port C half that is configured as input. The latch changes while reads keep returning the pin value. A behavioural model in the bench tracks the registers and the held-strobe condition, and it judges all outputs on every falling clock edge.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int NUM_NIB  = (3 * BYTE_W) / NIB_W;
    localparam int ADDR_W   = 2;
    localparam int IDX_W    = $clog2(BYTE_W);

    typedef enum logic [ADDR_W-1:0] {
        SEL_PA   = 2'd0,
        SEL_PB   = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_HOLD = 1'b1
    } bus_state_e;

    // Direction bit position in the configuration word for each nibble
    // nibbles 0,1 = port A; 2,3 = port B; 4 = port C low; 5 = port C high
    function automatic int nib_dir_bit(input int n);
        case (n)
            0, 1:    return 4;
            2, 3:    return 1;
            4:       return 0;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/pport_bus_fsm.sv
module pport_bus_fsm
    import pport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_commit,
    output logic rd_active
);
    bus_state_e state_q, state_d;
    logic wr_req;

    assign wr_req = !cs_n && !wr_n;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        wr_commit = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (wr_req) begin
                    wr_commit = 1'b1;
                    state_d   = BUS_HOLD;
                end
            end
            BUS_HOLD: begin
                if (!wr_req) state_d = BUS_IDLE;
            end
        endcase
    end

    assign rd_active = !cs_n && !rd_n && wr_n;

    // R8
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              cfg_q,
    output logic [BYTE_W-1:0] pa_q,
    output logic [BYTE_W-1:0] pb_q,
    output logic [BYTE_W-1:0] pc_q
);
    logic setup_wr, bsr_wr;
    logic [IDX_W-1:0] bsr_idx;

    assign setup_wr = wr_commit && (addr == SEL_CTRL) && wdata[BYTE_W-1];
    assign bsr_wr   = wr_commit && (addr == SEL_CTRL) && !wdata[BYTE_W-1];
    assign bsr_idx  = wdata[IDX_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= 1'b0;
            pa_q   <= '0;
            pb_q   <= '0;
            pc_q   <= '0;
        end else if (setup_wr) begin
            ctrl_q <= wdata;
            cfg_q  <= 1'b1;
            pa_q   <= '0;
            pb_q   <= '0;
            pc_q   <= '0;
        end else if (bsr_wr) begin
            pc_q[bsr_idx] <= wdata[0];
        end else if (wr_commit) begin
            unique case (reg_sel_e'(addr))
                SEL_PA:   pa_q <= wdata;
                SEL_PB:   pb_q <= wdata;
                SEL_PC:   pc_q <= wdata;
                SEL_CTRL: ;
            endcase
        end
    end

    // R5
    setup_clear_chk: assert property (@(posedge clk) disable iff (rst)
        setup_wr |=> (pa_q == '0 && pb_q == '0 && pc_q == '0));
    // R6
    bsr_ctrl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        bsr_wr |=> $stable(ctrl_q));
    // R6
    bsr_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        bsr_wr |=> ($countones(pc_q ^ $past(pc_q)) <= 1));
endmodule

// File: rtl/pport_nibble.sv
module pport_nibble #(
    parameter int W = 4
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pin,
    input  logic         is_out,
    output logic [W-1:0] drv,
    output logic [W-1:0] oe,
    output logic [W-1:0] rd
);
    assign drv = latch;
    assign oe  = {W{is_out}};
    assign rd  = is_out ? latch : pin;
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        rdata_oe,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);
    localparam int ALL_W = NUM_NIB * NIB_W;

    logic              wr_commit, rd_active, cfg_q;
    logic [BYTE_W-1:0] ctrl_q, pa_q, pb_q, pc_q;
    logic [ALL_W-1:0]  latch_all, pin_all, drv_all, oe_all, rd_all;
    logic [BYTE_W-1:0] rd_mux;

    pport_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wr_commit(wr_commit), .rd_active(rd_active)
    );

    pport_regs u_regs (
        .clk(clk), .rst(rst), .wr_commit(wr_commit), .addr(addr), .wdata(wdata),
        .ctrl_q(ctrl_q), .cfg_q(cfg_q), .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q)
    );

    assign latch_all = {pc_q, pb_q, pa_q};
    assign pin_all   = {pc_in, pb_in, pa_in};

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
        localparam int DB = nib_dir_bit(n);
        pport_nibble #(.W(NIB_W)) u_nib (
            .latch (latch_all[n*NIB_W +: NIB_W]),
            .pin   (pin_all[n*NIB_W +: NIB_W]),
            .is_out(cfg_q && !ctrl_q[DB]),
            .drv   (drv_all[n*NIB_W +: NIB_W]),
            .oe    (oe_all[n*NIB_W +: NIB_W]),
            .rd    (rd_all[n*NIB_W +: NIB_W])
        );
    end

    assign {pc_out, pb_out, pa_out} = drv_all;
    assign {pc_oe,  pb_oe,  pa_oe}  = oe_all;

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_PA:   rd_mux = rd_all[0 +: BYTE_W];
            SEL_PB:   rd_mux = rd_all[BYTE_W +: BYTE_W];
            SEL_PC:   rd_mux = rd_all[2*BYTE_W +: BYTE_W];
            SEL_CTRL: rd_mux = ctrl_q;
        endcase
    end

    assign rdata_oe = rd_active;
    assign rdata    = rd_active ? rd_mux : '0;

    // R2
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !rdata_oe);
    // R1
    unconfigured_input_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0));
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !rdata_oe);
endmodule

// File: tb/pport_ctrl_tb.sv
module pport_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       rdata_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R1";

    // behavioural reference state
    logic [7:0] m_ctrl, m_a, m_b, m_c;
    logic       m_cfg, m_hold;

    always #5 clk = ~clk;

    pport_ctrl dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl <= 8'h00; m_a <= 8'h00; m_b <= 8'h00; m_c <= 8'h00;
            m_cfg <= 1'b0; m_hold <= 1'b0;
        end else if (!cs_n && !wr_n) begin
            m_hold <= 1'b1;
            if (!m_hold) begin
                case (addr)
                    2'd0: m_a <= wdata;
                    2'd1: m_b <= wdata;
                    2'd2: m_c <= wdata;
                    default: begin
                        if (wdata[7]) begin
                            m_ctrl <= wdata; m_cfg <= 1'b1;
                            m_a <= 8'h00; m_b <= 8'h00; m_c <= 8'h00;
                        end else begin
                            m_c[wdata[3:1]] <= wdata[0];
                        end
                    end
                endcase
            end
        end else begin
            m_hold <= 1'b0;
        end
    end

    function automatic logic [7:0] exp_oe(input int dbit);
        return (m_cfg && !m_ctrl[dbit]) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] exp_pc_oe();
        return {exp_oe(3)[3:0], exp_oe(0)[3:0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        logic [7:0] coe;
        coe = exp_pc_oe();
        case (a)
            2'd0: return (exp_oe(4) & m_a) | (~exp_oe(4) & pa_in);
            2'd1: return (exp_oe(1) & m_b) | (~exp_oe(1) & pb_in);
            2'd2: return (coe & m_c) | (~coe & pc_in);
            default: return m_ctrl;
        endcase
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (!rst) begin
            logic e_oe;
            e_oe = !cs_n && !rd_n && wr_n;
            cmp(phase, "pa_out", pa_out, m_a);
            cmp(phase, "pb_out", pb_out, m_b);
            cmp(phase, "pc_out", pc_out, m_c);
            cmp(phase, "pa_oe", pa_oe, exp_oe(4));
            cmp(phase, "pb_oe", pb_oe, exp_oe(1));
            cmp(phase, "pc_oe", pc_oe, exp_pc_oe());
            cmp(phase, "rdata_oe", {7'd0, rdata_oe}, {7'd0, e_oe});
            cmp(phase, "rdata", rdata, e_oe ? exp_read(addr) : 8'h00);
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        @(negedge clk);
        cmp(req, "read strobe oe", {7'd0, rdata_oe}, 8'h01);
        cmp(req, "read value", rdata, exp);
        @(posedge clk); #1;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        cmp("R1", "pa_oe after reset", pa_oe, 8'h00);
        cmp("R1", "pc_out after reset", pc_out, 8'h00);
        read_chk(2'd3, 8'h00, "R1");

        // R2: deselected strobes
        phase = "R2";
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd3; wdata = 8'h80;
        @(posedge clk); #1;
        rd_n = 1'b0; wr_n = 1'b1;
        @(negedge clk);
        cmp("R2", "rdata_oe with cs_n high", {7'd0, rdata_oe}, 8'h00);
        @(posedge clk); #1 rd_n = 1'b1;
        read_chk(2'd3, 8'h00, "R2");

        // R3 / R4: all outputs, write each port
        phase = "R4";
        bus_write(2'd3, 8'h80);
        read_chk(2'd3, 8'h80, "R4");
        cmp("R4", "pa_oe all output", pa_oe, 8'hFF);
        phase = "R3";
        bus_write(2'd0, 8'h5A);
        bus_write(2'd1, 8'hC3);
        bus_write(2'd2, 8'h96);
        read_chk(2'd0, 8'h5A, "R3");
        read_chk(2'd1, 8'hC3, "R3");
        read_chk(2'd2, 8'h96, "R3");

        // R6: bit set/reset
        phase = "R6";
        bus_write(2'd3, 8'h01);        // bit0 <- 1
        read_chk(2'd2, 8'h97, "R6");
        bus_write(2'd3, 8'h0E);        // bit7 <- 0
        read_chk(2'd2, 8'h17, "R6");
        bus_write(2'd3, 8'h75);        // bits 6:4 junk, bit2 <- 1
        read_chk(2'd2, 8'h17, "R6");
        bus_write(2'd3, 8'h78);        // junk, bit4 <- 0
        read_chk(2'd2, 8'h07, "R6");
        read_chk(2'd3, 8'h80, "R6");

        // R5 / R7: mixed directions, latches cleared
        phase = "R5";
        pa_in = 8'h3C; pb_in = 8'hA5; pc_in = 8'hE1;
        bus_write(2'd3, 8'h8A);        // A out, C hi in, B in, C lo out
        cmp("R5", "pa_out cleared", pa_out, 8'h00);
        cmp("R5", "pc_out cleared", pc_out, 8'h00);
        phase = "R7";
        cmp("R7", "pc_oe split", pc_oe, 8'h0F);
        read_chk(2'd1, 8'hA5, "R7");
        read_chk(2'd2, 8'hE0, "R7");
        bus_write(2'd2, 8'h5B);
        read_chk(2'd2, 8'hEB, "R7");
        bus_write(2'd3, 8'h0F);        // bit7 of C (an input half) <- 1
        read_chk(2'd2, 8'hEB, "R7");
        cmp("R7", "pc_out latch updated", pc_out, 8'hDB);
        bus_write(2'd0, 8'h69);
        read_chk(2'd0, 8'h69, "R7");

        // R8: held strobe commits once
        phase = "R8";
        @(posedge clk); #1;
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; wdata = 8'h11;
        @(posedge clk); #1 wdata = 8'h22;
        @(posedge clk); #1 addr = 2'd2; wdata = 8'h33;
        @(posedge clk); #1 cs_n = 1'b1; wr_n = 1'b1;
        read_chk(2'd0, 8'h11, "R8");
        cmp("R8", "pc_out untouched", pc_out, 8'hDB);

        // R9: mode fields stored, basic behaviour kept
        phase = "R9";
        bus_write(2'd3, 8'hE4);
        read_chk(2'd3, 8'hE4, "R9");
        cmp("R9", "pb_oe", pb_oe, 8'hFF);
        bus_write(2'd1, 8'h42);
        read_chk(2'd1, 8'h42, "R9");

        // R10: read and write together
        phase = "R10";
        @(posedge clk); #1;
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; addr = 2'd1; wdata = 8'h7E;
        @(negedge clk);
        cmp("R10", "rdata_oe during collision", {7'd0, rdata_oe}, 8'h00);
        @(posedge clk); #1 cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        read_chk(2'd1, 8'h7E, "R10");

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule